// File: doc/BRIEF.md
# SD Host Normal Interrupt Status

This block holds the normal (non-error) interrupt status of an SD host controller. It watches the controller's internal transfer-state levels and pulses and turns particular edges of them into sticky status bits. The monitored levels are the buffer-read-enable and buffer-write-enable flags, the data-line-active flag, and the read-transfer-active and write-transfer-active flags. The monitored pulses are the SDMA boundary pulse, the ADMA descriptor interrupt pulse and the command-done pulse. Each edge is found by comparing a level with its registered copy from the previous clock edge. The status bit is set at the same clock edge where the level is first seen changed.

Software reaches three registers through a plain write/select port with a combinational read-back. The first is the status register, which is cleared by writing ones. The second is a status-enable mask, which decides which events get latched. The third is a signal-enable mask, which decides which latched bits drive the single OR-reduced interrupt line. The port carries register accesses only, not a data stream, so it has no valid/ready handshake: a write takes effect at the clock edge where `reg_wr` is 1, and no back-pressure exists.

Top module: `sd_norm_int_status`

## Requirements
- R1: While `rst_n` is 0 at a clock edge, the status bits, both masks and the internal completion flag are cleared, so `status` reads 0 and `irq` is 0 after that edge.
- R2: Status bit 5 (read buffer ready) sets at the edge where `buf_rd_en` is 1 and was 0 at the previous edge.
- R3: Status bit 4 (write buffer ready) sets at the edge where `buf_wr_en` is 1 and was 0 at the previous edge.
- R4: Status bit 1 (transfer done) sets at the edge where `rd_xfer_active` or `wr_xfer_active` is 0 and was 1 at the previous edge.
- R5: Status bit 2 (stopped at gap) sets at an edge where `dat_active` or `wr_xfer_active` has fallen, but only if `stop_at_gap` is 1 at that edge. Otherwise the bit is never set.
- R6: Status bit 3 (DMA event) sets on an edge with `sdma_boundary` or `adma_desc_int` high. It is suppressed from the edge that detects a transfer-done fall until the next edge at which `rd_xfer_active` or `wr_xfer_active` rises. It is also suppressed at that fall edge itself.
- R7: Status bit 0 (command done) sets on an edge with `cmd_done` high.
- R8: Writing with `reg_sel`=0 clears each status bit whose `reg_wdata` bit is 1. Zero bits leave the status unchanged, and such a write leaves both masks unchanged.
- R9: When a set event and a clearing write hit the same status bit at the same edge, the bit ends up 1.
- R10: An event for bit i is latched only if bit i of the status-enable mask (`reg_sel`=1) is 1. Clearing a mask bit does not clear a status bit that is already set.
- R11: `irq` is 1 exactly when some bit is set in both `status` and the signal-enable mask (`reg_sel`=2).
- R12: `reg_rdata` combinationally shows status for `reg_sel`=0, the status-enable mask for 1, the signal-enable mask for 2 and zero for 3. A write with `reg_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_rd_en | input | 1 | Read buffer has data for the host (level) |
| buf_wr_en | input | 1 | Write buffer has room (level) |
| dat_active | input | 1 | Data lines busy (level) |
| rd_xfer_active | input | 1 | Read transfer in progress (level) |
| wr_xfer_active | input | 1 | Write transfer in progress (level) |
| stop_at_gap | input | 1 | Stop-at-block-gap request control bit |
| sdma_boundary | input | 1 | SDMA buffer boundary reached (pulse) |
| adma_desc_int | input | 1 | ADMA descriptor with interrupt flag processed (pulse) |
| cmd_done | input | 1 | Command complete (pulse) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 status enable, 2 signal enable |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Selected register value |
| status | output | 6 | Latched status bits |
| irq | output | 1 | OR of status bits enabled for signalling |

## Verification
The hazard that matters is a write-one-to-clear landing at the same edge as a fresh set event for the same bit. Set must win, and a bit not hit by an event must still clear. The directed part pulses `cmd_done` during a clearing write and then clears with no event. The random part issues status writes at the same time as random edges on every monitored line. A bench model judges each edge: it applies the clear mask first and then ORs in the enabled events. A second collision tested is a DMA pulse arriving at or just after a transfer-done fall, which must be dropped.

// File: rtl/sdis_pkg.sv
package sdis_pkg;
  // status bit positions (software decodes these)
  localparam int unsigned NB      = 6;
  localparam int unsigned B_CMD   = 0;
  localparam int unsigned B_DONE  = 1;
  localparam int unsigned B_GAP   = 2;
  localparam int unsigned B_DMA   = 3;
  localparam int unsigned B_WRRDY = 4;
  localparam int unsigned B_RDRDY = 5;

  // monitored level indices
  localparam int unsigned LVL_W    = 5;
  localparam int unsigned L_BUFRD  = 0;
  localparam int unsigned L_BUFWR  = 1;
  localparam int unsigned L_DAT    = 2;
  localparam int unsigned L_RDACT  = 3;
  localparam int unsigned L_WRACT  = 4;

  // register select codes
  localparam int unsigned SEL_W   = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_STS   = 2'd0,
    SEL_STEN  = 2'd1,
    SEL_SIGEN = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sdis_edge_bank.sv
module sdis_edge_bank #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_edge
    // reset captures the level so no false edge appears on release
    always_ff @(posedge clk) begin
      prev_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q[g];
    assign fall[g] = ~lvl[g] & prev_q[g];
  end

  logic unused_rst;
  assign unused_rst = rst_n;
endmodule

// File: rtl/sdis_event_qual.sv
module sdis_event_qual
  import sdis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rise,
  input  logic [LVL_W-1:0] fall,
  input  logic             stop_at_gap,
  input  logic             sdma_boundary,
  input  logic             adma_desc_int,
  input  logic             cmd_done,
  output logic [NB-1:0]    evt
);
  logic done_q;
  logic done_ev;
  logic start_ev;

  assign done_ev  = fall[L_RDACT] | fall[L_WRACT];
  assign start_ev = rise[L_RDACT] | rise[L_WRACT];

  // remembers that the current transfer has finished
  always_ff @(posedge clk) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (done_ev)  done_q <= 1'b1;
    else if (start_ev) done_q <= 1'b0;
  end

  always_comb begin
    evt          = '0;
    evt[B_RDRDY] = rise[L_BUFRD];
    evt[B_WRRDY] = rise[L_BUFWR];
    evt[B_DMA]   = (sdma_boundary | adma_desc_int) & ~done_q & ~done_ev;
    evt[B_GAP]   = stop_at_gap & (fall[L_DAT] | fall[L_WRACT]);
    evt[B_DONE]  = done_ev;
    evt[B_CMD]   = cmd_done;
  end
endmodule

// File: rtl/sdis_w1c_bank.sv
module sdis_w1c_bank #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      q[g] <= 1'b0;
      else if (set[g]) q[g] <= 1'b1;
      else if (clr[g]) q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/sdis_regs.sv
module sdis_regs
  import sdis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [NB-1:0]    reg_wdata,
  input  logic [NB-1:0]    sts,
  output logic [NB-1:0]    sts_en,
  output logic [NB-1:0]    sig_en,
  output logic [NB-1:0]    clr,
  output logic [NB-1:0]    rdata
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_en <= '0;
      sig_en <= '0;
    end else if (reg_wr) begin
      if (sel == SEL_STEN)  sts_en <= reg_wdata;
      if (sel == SEL_SIGEN) sig_en <= reg_wdata;
    end
  end

  assign clr = (reg_wr && sel == SEL_STS) ? reg_wdata : '0;

  always_comb begin
    unique case (sel)
      SEL_STS:   rdata = sts;
      SEL_STEN:  rdata = sts_en;
      SEL_SIGEN: rdata = sig_en;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/sd_norm_int_status.sv
module sd_norm_int_status
  import sdis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_rd_en,
  input  logic             buf_wr_en,
  input  logic             dat_active,
  input  logic             rd_xfer_active,
  input  logic             wr_xfer_active,
  input  logic             stop_at_gap,
  input  logic             sdma_boundary,
  input  logic             adma_desc_int,
  input  logic             cmd_done,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [NB-1:0]    reg_wdata,
  output logic [NB-1:0]    reg_rdata,
  output logic [NB-1:0]    status,
  output logic             irq
);
  logic [LVL_W-1:0] lvl;
  logic [LVL_W-1:0] rise;
  logic [LVL_W-1:0] fall;
  logic [NB-1:0]    evt;
  logic [NB-1:0]    sts_en_q;
  logic [NB-1:0]    sig_en_q;
  logic [NB-1:0]    clr;

  always_comb begin
    lvl          = '0;
    lvl[L_BUFRD] = buf_rd_en;
    lvl[L_BUFWR] = buf_wr_en;
    lvl[L_DAT]   = dat_active;
    lvl[L_RDACT] = rd_xfer_active;
    lvl[L_WRACT] = wr_xfer_active;
  end

  sdis_edge_bank #(.W(LVL_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall)
  );

  sdis_event_qual u_qual (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .stop_at_gap(stop_at_gap), .sdma_boundary(sdma_boundary),
    .adma_desc_int(adma_desc_int), .cmd_done(cmd_done), .evt(evt)
  );

  sdis_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .sts(status), .sts_en(sts_en_q),
    .sig_en(sig_en_q), .clr(clr), .rdata(reg_rdata)
  );

  sdis_w1c_bank #(.W(NB)) u_sts (
    .clk(clk), .rst_n(rst_n), .set(evt & sts_en_q), .clr(clr), .q(status)
  );

  assign irq = |(status & sig_en_q);
endmodule

// File: rtl/sd_norm_int_status_chk.sv
module sd_norm_int_status_chk
  import sdis_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             buf_rd_en,
  input logic             rd_xfer_active,
  input logic             stop_at_gap,
  input logic             sdma_boundary,
  input logic             adma_desc_int,
  input logic             cmd_done,
  input logic             reg_wr,
  input logic [SEL_W-1:0] reg_sel,
  input logic [NB-1:0]    reg_wdata,
  input logic [NB-1:0]    status,
  input logic [NB-1:0]    sts_en,
  input logic [NB-1:0]    sig_en,
  input logic             irq
);
  // R1
  rst_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (status == '0 && !irq));

  // R2
  rd_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_rd_en) && sts_en[B_RDRDY] |=> status[B_RDRDY]);

  // R5
  gap_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_at_gap && !status[B_GAP] |=> !status[B_GAP]);

  // R6
  dma_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_xfer_active) ##1 ((sdma_boundary || adma_desc_int) && !status[B_DMA])
    |=> !status[B_DMA]);

  // R7
  cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && sts_en[B_CMD] |=> status[B_CMD]);

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_done && reg_wr && reg_sel == SEL_STS && reg_wdata[B_CMD] |=> !status[B_CMD]);

  // R9
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && sts_en[B_CMD] && reg_wr && reg_sel == SEL_STS && reg_wdata[B_CMD]
    |=> status[B_CMD]);

  // R10
  gate_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_en[B_DONE] && !status[B_DONE] |=> !status[B_DONE]);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_en == '0 |-> !irq);
endmodule

bind sd_norm_int_status sd_norm_int_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .buf_rd_en(buf_rd_en),
  .rd_xfer_active(rd_xfer_active), .stop_at_gap(stop_at_gap),
  .sdma_boundary(sdma_boundary), .adma_desc_int(adma_desc_int),
  .cmd_done(cmd_done), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .status(status), .sts_en(sts_en_q),
  .sig_en(sig_en_q), .irq(irq)
);

// File: tb/test_sd_norm_int_status.sv
module test_sd_norm_int_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_rd_en = 0, buf_wr_en = 0, dat_active = 0, rd_xfer_active = 0;
  logic wr_xfer_active = 0, stop_at_gap = 0, sdma_boundary = 0;
  logic adma_desc_int = 0, cmd_done = 0, reg_wr = 0;
  logic [1:0] reg_sel = 2'd0;
  logic [5:0] reg_wdata = 6'd0;
  logic [5:0] reg_rdata, status;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [4:0] m_prev = '0;
  logic [5:0] m_sts = '0, m_sten = '0, m_sig = '0;
  logic       m_done = 1'b0;

  always #4 clk = ~clk;

  sd_norm_int_status i_sd_norm_int_status (
    .clk(clk), .rst_n(rst_n), .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
    .dat_active(dat_active), .rd_xfer_active(rd_xfer_active),
    .wr_xfer_active(wr_xfer_active), .stop_at_gap(stop_at_gap),
    .sdma_boundary(sdma_boundary), .adma_desc_int(adma_desc_int),
    .cmd_done(cmd_done), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status(status), .irq(irq)
  );

  function automatic string req_of(int b);
    case (b)
      5: return "R2"; 4: return "R3"; 3: return "R6";
      2: return "R5"; 1: return "R4"; default: return "R7";
    endcase
  endfunction

  function automatic logic [4:0] levels();
    return {wr_xfer_active, rd_xfer_active, dat_active, buf_wr_en, buf_rd_en};
  endfunction

  function automatic logic [5:0] events(logic [4:0] l, logic [4:0] p, logic dn);
    logic [4:0] r, f;
    logic de;
    logic [5:0] e;
    r = l & ~p; f = ~l & p;
    de = f[3] | f[4];
    e[5] = r[0];
    e[4] = r[1];
    e[3] = (sdma_boundary | adma_desc_int) & ~dn & ~de;
    e[2] = stop_at_gap & (f[2] | f[4]);
    e[1] = de;
    e[0] = cmd_done;
    return e;
  endfunction

  task automatic check(string rq, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", rq, act, exp, $time);
    end
  endtask

  // one clock edge: predict, step, compare 2 ns after the edge
  task automatic step();
    logic [4:0] l, r, f;
    logic [5:0] ns, clr;
    logic nd;
    l = levels();
    r = l & ~m_prev; f = ~l & m_prev;
    if (!rst_n) begin
      ns = '0; m_sten = '0; m_sig = '0; nd = 1'b0;
    end else begin
      clr = (reg_wr && reg_sel == 2'd0) ? reg_wdata : '0;
      ns = (m_sts & ~clr) | (events(l, m_prev, m_done) & m_sten);
      nd = (f[3] | f[4]) ? 1'b1 : (r[3] | r[4]) ? 1'b0 : m_done;
      if (reg_wr && reg_sel == 2'd1) m_sten = reg_wdata;
      if (reg_wr && reg_sel == 2'd2) m_sig = reg_wdata;
    end
    @(posedge clk);
    m_prev = l; m_sts = ns; m_done = nd;
    #2;
    for (int b = 0; b < 6; b++)
      if (status[b] !== m_sts[b]) check(req_of(b), status, m_sts);
    check("R11", {5'd0, irq}, {5'd0, |(m_sts & m_sig)});
    check("R12", reg_rdata,
          reg_sel == 2'd0 ? m_sts : reg_sel == 2'd1 ? m_sten :
          reg_sel == 2'd2 ? m_sig : 6'd0);
    checks++;
  endtask

  task automatic idle();
    reg_wr = 0; cmd_done = 0; sdma_boundary = 0; adma_desc_int = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [5:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    buf_rd_en = 1;  // high during reset: no false rise on release
    step(); step();
    check("R1", status, 6'd0);
    check("R1", {5'd0, irq}, 6'd0);
    rst_n = 1;
    reg_sel = 2'd1; step();
    check("R1", reg_rdata, 6'd0);
    check("R2", status, 6'd0);

    // enable everything
    wr(2'd1, 6'h3F); step(); wr(2'd2, 6'h3F); step(); idle();
    // R8: zeros in a status write leave masks alone
    wr(2'd0, 6'h00); step(); idle(); reg_sel = 2'd1; step();
    check("R8", reg_rdata, 6'h3F);

    // R9: cmd_done and clear of bit0 in the same edge
    cmd_done = 1; step(); idle();
    cmd_done = 1; wr(2'd0, 6'h01); step(); idle();
    check("R9", status & 6'h01, 6'h01);
    wr(2'd0, 6'h01); step(); idle();
    check("R8", status & 6'h01, 6'h00);

    // R5: write-active fall without stop request
    stop_at_gap = 0; wr_xfer_active = 1; step(); wr_xfer_active = 0; step();
    check("R5", status & 6'h04, 6'h00);
    check("R4", status & 6'h02, 6'h02);
    // R6: DMA right after transfer done is dropped
    sdma_boundary = 1; step(); idle();
    check("R6", status & 6'h08, 6'h00);
    // new transfer restarts DMA reporting
    rd_xfer_active = 1; step(); adma_desc_int = 1; step(); idle();
    check("R6", status & 6'h08, 6'h08);
    // R5: with stop request, data-line fall sets gap
    stop_at_gap = 1; dat_active = 1; step(); dat_active = 0; step();
    check("R5", status & 6'h04, 6'h04);
    // R10: mask off clears nothing, blocks new sets
    wr(2'd0, 6'h3F); step(); wr(2'd1, 6'h00); cmd_done = 1; step(); idle();
    check("R10", status & 6'h01, 6'h01);
    wr(2'd0, 6'h3F); step(); idle(); cmd_done = 1; step(); idle();
    check("R10", status, 6'h00);
    // R12: select 3 write ignored
    wr(2'd3, 6'h15); step(); idle(); reg_sel = 2'd2; step();
    check("R12", reg_rdata, 6'h3F);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(3) == 0) buf_rd_en = ~buf_rd_en;
      if ($urandom_range(3) == 0) buf_wr_en = ~buf_wr_en;
      if ($urandom_range(3) == 0) dat_active = ~dat_active;
      if ($urandom_range(5) == 0) rd_xfer_active = ~rd_xfer_active;
      if ($urandom_range(5) == 0) wr_xfer_active = ~wr_xfer_active;
      if ($urandom_range(7) == 0) stop_at_gap = ~stop_at_gap;
      sdma_boundary = ($urandom_range(5) == 0);
      adma_desc_int = ($urandom_range(7) == 0);
      cmd_done = ($urandom_range(5) == 0);
      reg_wr = ($urandom_range(2) == 0);
      reg_sel = 2'($urandom_range(3));
      reg_wdata = 6'($urandom_range(63));
      if (reg_sel == 2'd1 && $urandom_range(3) != 0) reg_wdata = 6'h3F;
      step();
    end
    idle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule